// File: doc/BRIEF.md
# Decode-Stage Hazard and Bypass Controller

This combinational block steers operand bypassing and pipeline flow for a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback). Each instruction spends five cycles in flight. Operands are bypassed into the decode stage, so the block compares the two source register numbers being decoded against the destination registers held by the execute, memory and writeback stages. For each operand it produces a 2-bit bypass select, and the nearest producer wins.

When the instruction in execute is a load whose result a decode source needs, the value is not yet available. The block then holds the program counter and the fetch/decode register for one cycle and turns the decode/execute register into a bubble. In the following cycle the load sits in memory and its value is bypassed from there. Branches are predicted not taken. When execute reports a taken branch or jump, the two younger instructions are squashed by bubbling the fetch/decode and decode/execute registers, which costs two cycles. A squash always overrides a stall in the same cycle.

With no hazard present, every control output is low and one instruction issues per cycle.

Top module: `hazard_fwd_unit`

## Requirements
- R1: Each operand select is encoded as 00 register file, 01 writeback, 10 memory, 11 execute. When several stages write the needed register, execute is chosen over memory, and memory is chosen over writeback.
- R2: A source register number of zero never produces a bypass select other than 00 and never causes a stall.
- R3: A stage whose write-enable input is low is never selected and never causes a stall, even if its destination matches.
- R4: An operand whose "used" input is low gets select 00 and cannot cause a stall.
- R5: If execute holds a load (write enabled, nonzero destination) that matches a used decode source, and no redirect is present, then `pc_hold`, `ifid_hold` and `idex_bubble` are 1 and `ifid_bubble` is 0.
- R6: A matching producer in the memory stage with no matching producer in execute yields select 10 with no stall, whether or not that producer is a load.
- R7: When `ex_redirect` is 1, `ifid_bubble` and `idex_bubble` are 1.
- R8: When `ex_redirect` is 1, `pc_hold` and `ifid_hold` are 0, even if a load-use condition exists.
- R9: With no load-use condition and no redirect, all four flow-control outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs1 | input | REG_W | First source register number in decode |
| id_rs2 | input | REG_W | Second source register number in decode |
| id_uses_rs1 | input | 1 | Decoded instruction reads its first source |
| id_uses_rs2 | input | 1 | Decoded instruction reads its second source |
| ex_rd | input | REG_W | Destination register in execute |
| ex_wen | input | 1 | Execute instruction writes a register |
| ex_is_load | input | 1 | Execute instruction is a load |
| ex_redirect | input | 1 | Branch or jump in execute resolved taken |
| mem_rd | input | REG_W | Destination register in memory stage |
| mem_wen | input | 1 | Memory-stage instruction writes a register |
| wb_rd | input | REG_W | Destination register in writeback |
| wb_wen | input | 1 | Writeback instruction writes a register |
| fwd_a | output | 2 | Bypass select for first operand |
| fwd_b | output | 2 | Bypass select for second operand |
| pc_hold | output | 1 | Keep program counter unchanged |
| ifid_hold | output | 1 | Keep fetch/decode register unchanged |
| ifid_bubble | output | 1 | Replace fetch/decode contents with a bubble |
| idex_bubble | output | 1 | Replace decode/execute contents with a bubble |

## Verification
The embedded assertions check, on every input change, the following properties. A matching execute producer always takes select 11. Zero or unused sources always get select 00. A hold never coincides with a fetch/decode bubble. A redirect always bubbles both registers without holding. A hold always comes with a decode/execute bubble. Only the bench's sweep can show the full priority chain among three matching producers, how write-enable masking interacts with the chain, and the exact set of flow outputs for each combination of load-use and redirect. That sweep covers every input combination of a 2-bit register-number configuration.

// File: rtl/hazard_fwd_unit.sv
module hazard_fwd_unit #(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] id_rs1,
  input  logic [REG_W-1:0] id_rs2,
  input  logic             id_uses_rs1,
  input  logic             id_uses_rs2,
  input  logic [REG_W-1:0] ex_rd,
  input  logic             ex_wen,
  input  logic             ex_is_load,
  input  logic             ex_redirect,
  input  logic [REG_W-1:0] mem_rd,
  input  logic             mem_wen,
  input  logic [REG_W-1:0] wb_rd,
  input  logic             wb_wen,
  output logic [1:0]       fwd_a,
  output logic [1:0]       fwd_b,
  output logic             pc_hold,
  output logic             ifid_hold,
  output logic             ifid_bubble,
  output logic             idex_bubble
);

  localparam logic [1:0] SEL_RF  = 2'b00;
  localparam logic [1:0] SEL_WB  = 2'b01;
  localparam logic [1:0] SEL_MEM = 2'b10;
  localparam logic [1:0] SEL_EX  = 2'b11;

  function automatic logic hit(input logic [REG_W-1:0] rs, input logic used,
                               input logic [REG_W-1:0] rd, input logic wen);
    return used && wen && (rs != '0) && (rs == rd);
  endfunction

  logic ex_a, mem_a, wb_a, ex_b, mem_b, wb_b, load_use;

  assign ex_a  = hit(id_rs1, id_uses_rs1, ex_rd,  ex_wen);
  assign mem_a = hit(id_rs1, id_uses_rs1, mem_rd, mem_wen);
  assign wb_a  = hit(id_rs1, id_uses_rs1, wb_rd,  wb_wen);
  assign ex_b  = hit(id_rs2, id_uses_rs2, ex_rd,  ex_wen);
  assign mem_b = hit(id_rs2, id_uses_rs2, mem_rd, mem_wen);
  assign wb_b  = hit(id_rs2, id_uses_rs2, wb_rd,  wb_wen);

  assign fwd_a = ex_a ? SEL_EX : mem_a ? SEL_MEM : wb_a ? SEL_WB : SEL_RF;
  assign fwd_b = ex_b ? SEL_EX : mem_b ? SEL_MEM : wb_b ? SEL_WB : SEL_RF;

  assign load_use    = ex_is_load && (ex_a || ex_b);
  assign pc_hold     = load_use && !ex_redirect;
  assign ifid_hold   = pc_hold;
  assign ifid_bubble = ex_redirect;
  assign idex_bubble = pc_hold || ex_redirect;

  always_comb begin
    assert_ex_wins_R1: assert (!(ex_wen && id_uses_rs1 && id_rs1 != '0 && id_rs1 == ex_rd) || fwd_a == SEL_EX)
      else $error("ex producer not selected");
    assert_zero_src_R2: assert (id_rs2 != '0 || fwd_b == SEL_RF)
      else $error("x0 bypassed");
    assert_unused_src_R4: assert (id_uses_rs1 || fwd_a == SEL_RF)
      else $error("unused operand bypassed");
    assert_hold_bubbles_R5: assert (!pc_hold || (ifid_hold && idex_bubble))
      else $error("hold without bubble");
    assert_redirect_flush_R7: assert (!ex_redirect || (ifid_bubble && idex_bubble))
      else $error("redirect not flushed");
    assert_flush_over_stall_R8: assert (!(ifid_bubble && (ifid_hold || pc_hold)))
      else $error("hold during flush");
  end

endmodule

// File: tb/tb_hazard_fwd_unit.sv
module tb_hazard_fwd_unit;
  localparam int W = 2;

  logic clk = 0;
  always #2.5 clk = ~clk;

  logic [W-1:0] id_rs1, id_rs2, ex_rd, mem_rd, wb_rd;
  logic id_uses_rs1, id_uses_rs2, ex_wen, ex_is_load, ex_redirect, mem_wen, wb_wen;
  logic [1:0] fwd_a, fwd_b;
  logic pc_hold, ifid_hold, ifid_bubble, idex_bubble;

  int tests = 0, fails = 0;
  bit done = 0;

  hazard_fwd_unit #(.REG_W(W)) dut (.*);

  function automatic logic [1:0] exp_sel(input logic [W-1:0] rs, input logic u,
                                         output string tag);
    logic e, m, b;
    e = u && rs != 0 && ex_wen  && ex_rd  == rs;
    m = u && rs != 0 && mem_wen && mem_rd == rs;
    b = u && rs != 0 && wb_wen  && wb_rd  == rs;
    if (!u) tag = "R4";
    else if (rs == 0) tag = "R2";
    else if ((ex_rd == rs && !ex_wen) || (mem_rd == rs && !mem_wen) || (wb_rd == rs && !wb_wen)) tag = "R3";
    else if (!e && m) tag = "R6";
    else tag = "R1";
    return e ? 2'd3 : m ? 2'd2 : b ? 2'd1 : 2'd0;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    {id_rs1, id_rs2, id_uses_rs1, id_uses_rs2, ex_rd, ex_wen, ex_is_load,
     mem_rd, mem_wen, wb_rd, wb_wen, ex_redirect} = '0;
    @(negedge clk);
    // idle state: R9
    check("R9", {fwd_a, fwd_b, pc_hold, ifid_hold, ifid_bubble, idex_bubble}, 0);

    for (int v = 0; v < (1 << 17); v++) begin
      logic [16:0] s;
      string ta, tb_, tc;
      logic [1:0] ea, eb;
      logic lu, rd;
      logic [3:0] ec;
      @(posedge clk);
      #1;
      s = v[16:0];
      id_rs1 = s[1:0]; id_rs2 = s[3:2]; id_uses_rs1 = s[4]; id_uses_rs2 = s[5];
      ex_rd = s[7:6]; ex_wen = s[8]; ex_is_load = s[9];
      mem_rd = s[11:10]; mem_wen = s[12]; wb_rd = s[14:13]; wb_wen = s[15];
      ex_redirect = s[16];
      @(negedge clk);
      ea = exp_sel(id_rs1, id_uses_rs1, ta);
      eb = exp_sel(id_rs2, id_uses_rs2, tb_);
      lu = ex_is_load && (ea == 2'd3 || eb == 2'd3);
      rd = ex_redirect;
      // {pc_hold, ifid_hold, ifid_bubble, idex_bubble}
      if (rd && lu) begin ec = 4'b0011; tc = "R8"; end
      else if (rd)  begin ec = 4'b0011; tc = "R7"; end
      else if (lu)  begin ec = 4'b1101; tc = "R5"; end
      else          begin ec = 4'b0000; tc = "R9"; end
      check(ta, fwd_a, ea);
      check(tb_, fwd_b, eb);
      check(tc, {pc_hold, ifid_hold, ifid_bubble, idex_bubble}, ec);
    end
    finish_run();
  end
endmodule